// File: doc/BRIEF.md
# Degree-4 Variable Node Processor with Compressed Messages

This block is the variable-side compute element of a min-sum low-density parity-check decoder whose check-to-variable messages travel in a 4-bit non-uniform code. Each cycle it can accept one set of four incoming edge messages and the intrinsic channel value of its code bit. It expands every 4-bit code to a representative magnitude, moves all values into a 9-bit two's-complement datapath, and forms the a-posteriori sum. For each edge it then removes that edge's own contribution, and it compresses the four extrinsic results back into 4-bit codes for the return trip to the check side.

The hard decision for the bit comes from the sign of the full sum. The datapath has two register levels: the first holds the expanded operands and the second holds the compressed results. The results therefore leave exactly two cycles after the operands are offered, and a fresh operand set can be offered on every cycle.

Top module: `vnode_pipe`

## Requirements
- R1: Edge k of `msg_in` sits in bits [4k+3:4k]. Bit 3 of each nibble is the sign (1 = negative) and bits 2:0 are the code. Codes 0..7 expand to magnitudes 1, 3, 5, 7, 9, 13, 20 and 28.
- R2: `chan_llr` is 6-bit sign-magnitude, with bit 5 as the sign (1 = negative) and bits 4:0 as the magnitude. A negative zero counts as zero.
- R3: The sum is the intrinsic value plus all four expanded messages. Output edge k is the sum minus the expanded message of edge k. Output edge k sits in `msg_out` bits [4k+3:4k] with the same nibble layout as the input.
- R4: An extrinsic result has its magnitude saturated at 31 and is then coded as follows: 0-1→0, 2-3→1, 4-5→2, 6-7→3, 8-10→4, 11-16→5, 17-24→6, 25-31→7. The nibble sign bit is 1 exactly when the result is negative.
- R5: An extrinsic result of zero is emitted as nibble 4'b0000, never with the sign bit set.
- R6: `hard_bit` is 1 when the sum is negative and 0 otherwise, including when the sum is zero.
- R7: An operand set accepted with `in_valid` high produces its results with `out_valid` high exactly two clock cycles later.
- R8: Operand sets may be offered on consecutive cycles without gaps, and each one yields its own result two cycles later.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `msg_out` and `hard_bit` become 0 after that edge.
- R10: Inputs offered with `in_valid` low are ignored. `msg_out` and `hard_bit` keep the last produced result, and `out_valid` is low for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set on `chan_llr`/`msg_in` is valid this cycle |
| chan_llr | input | 6 | Intrinsic channel value, sign-magnitude |
| msg_in | input | 16 | Four 4-bit compressed check-to-variable messages |
| out_valid | output | 1 | Results on `msg_out`/`hard_bit` are new this cycle |
| msg_out | output | 16 | Four 4-bit compressed variable-to-check messages |
| hard_bit | output | 1 | Hard decision of the code bit |

## Verification
Each of the eight codes is first swept on one edge while the others stay fixed, which separates a wrong expansion entry from a wrong adder. Mixed-sign sets are tuned so that one extrinsic result lands exactly on zero, on 31 and beyond, and on each compression boundary. These sets show whether saturation, the negative-zero rule and the sign handling behave correctly. A negative-zero intrinsic, a zero sum and strongly negative sums exercise the hard decision. A long back-to-back stream with random gaps, in which the inputs keep changing while `in_valid` is low, tells a correct two-cycle pipeline apart from one that drops or duplicates slots or lets idle inputs leak into the held result.

// File: rtl/vnode_pkg.sv
// Package vnode_pkg
// Shared constants and the two code-book functions of the compressed message
// format. Assumes a 3-bit code field and a 5-bit magnitude field.
package vnode_pkg;

    localparam int CODE_W  = 3;
    localparam int MAG_W   = 5;
    localparam int MAG_MAX = (1 << MAG_W) - 1;

    // Representative magnitude for each code (R1).
    function automatic logic [MAG_W-1:0] code_to_mag(input logic [CODE_W-1:0] c);
        logic [MAG_W-1:0] m;
        case (c)
            3'd0:    m = 5'd1;
            3'd1:    m = 5'd3;
            3'd2:    m = 5'd5;
            3'd3:    m = 5'd7;
            3'd4:    m = 5'd9;
            3'd5:    m = 5'd13;
            3'd6:    m = 5'd20;
            default: m = 5'd28;
        endcase
        return m;
    endfunction

    // Non-uniform quantiser of a saturated magnitude (R4).
    function automatic logic [CODE_W-1:0] mag_to_code(input logic [MAG_W-1:0] m);
        logic [CODE_W-1:0] c;
        if      (m <= 5'd1)  c = 3'd0;
        else if (m <= 5'd3)  c = 3'd1;
        else if (m <= 5'd5)  c = 3'd2;
        else if (m <= 5'd7)  c = 3'd3;
        else if (m <= 5'd10) c = 3'd4;
        else if (m <= 5'd16) c = 3'd5;
        else if (m <= 5'd24) c = 3'd6;
        else                 c = 3'd7;
        return c;
    endfunction

endpackage

// File: rtl/vnode_expand.sv
// Module vnode_expand
// Turns one sign-magnitude word into a two's-complement operand. If EXPAND is
// set, the magnitude field is a compressed code that is looked up first.
// Otherwise it is a plain magnitude. Assumes ACC_W exceeds the magnitude width.
module vnode_expand
    import vnode_pkg::*;
#(
    parameter int IN_W   = 4,
    parameter int ACC_W  = 9,
    parameter bit EXPAND = 1'b1
) (
    input  logic [IN_W-1:0]         word_in,
    output logic signed [ACC_W-1:0] value_out
);

    logic             neg;
    logic [MAG_W-1:0] mag;
    logic [ACC_W-1:0] mag_wide;

    assign neg = word_in[IN_W-1];

    generate
        if (EXPAND) begin : g_code
            // Code-book lookup of the magnitude.
            assign mag = code_to_mag(word_in[CODE_W-1:0]);
        end else begin : g_plain
            // Raw magnitude field.
            assign mag = word_in[MAG_W-1:0];
        end
    endgenerate

    assign mag_wide = ACC_W'(mag);

    // Apply the sign; a negated zero stays zero.
    always_comb begin
        value_out = neg ? -mag_wide : mag_wide;
    end

endmodule

// File: rtl/vnode_compress.sv
// Module vnode_compress
// Turns one two's-complement result into a 4-bit compressed code: the
// magnitude is saturated, then quantised, and the sign bit marks negative
// values only. Assumes the result fits in ACC_W bits.
module vnode_compress
    import vnode_pkg::*;
#(
    parameter int ACC_W = 9
) (
    input  logic signed [ACC_W-1:0] value_in,
    output logic [CODE_W:0]         code_out
);

    logic             neg;
    logic [ACC_W-1:0] abs_val;
    logic [MAG_W-1:0] sat_mag;

    assign neg = value_in[ACC_W-1];

    // Magnitude of the result.
    always_comb begin
        abs_val = neg ? -value_in : value_in;
    end

    // Clamp to the largest magnitude the 6-bit form can hold.
    always_comb begin
        if (abs_val > ACC_W'(MAG_MAX)) sat_mag = MAG_W'(MAG_MAX);
        else                           sat_mag = abs_val[MAG_W-1:0];
    end

    // Sign plus quantised code; zero is never negative here.
    assign code_out = {neg, mag_to_code(sat_mag)};

endmodule

// File: rtl/vnode_pipe.sv
// Module vnode_pipe
// Degree-DEG variable node processor. Stage 1 registers the expanded operands
// and stage 2 registers the compressed extrinsic outputs and the hard decision.
// Assumes ACC_W is wide enough for the intrinsic value plus DEG
// maximum-magnitude messages with no overflow.
module vnode_pipe
    import vnode_pkg::*;
#(
    parameter int DEG   = 4,
    parameter int LLR_W = 6,
    parameter int ACC_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [LLR_W-1:0]         chan_llr,
    input  logic [DEG*(CODE_W+1)-1:0] msg_in,
    output logic                     out_valid,
    output logic [DEG*(CODE_W+1)-1:0] msg_out,
    output logic                     hard_bit
);

    localparam int MSG_W = CODE_W + 1;

    logic signed [ACC_W-1:0] chan_tc;
    logic signed [ACC_W-1:0] msg_tc   [DEG];
    logic                    s1_valid;
    logic signed [ACC_W-1:0] s1_chan;
    logic signed [ACC_W-1:0] s1_msg   [DEG];
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] extr     [DEG];
    logic [MSG_W-1:0]        code_nx  [DEG];
    logic [DEG*MSG_W-1:0]    packed_nx;

    // Intrinsic value: plain sign-magnitude to two's complement.
    vnode_expand #(.IN_W(LLR_W), .ACC_W(ACC_W), .EXPAND(1'b0)) u_chan (
        .word_in   (chan_llr),
        .value_out (chan_tc)
    );

    generate
        for (genvar k = 0; k < DEG; k++) begin : g_in
            // Edge message: code-book expansion then two's complement.
            vnode_expand #(.IN_W(MSG_W), .ACC_W(ACC_W), .EXPAND(1'b1)) u_exp (
                .word_in   (msg_in[k*MSG_W +: MSG_W]),
                .value_out (msg_tc[k])
            );
        end
    endgenerate

    // Stage 1: capture expanded operands on an accepted slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_chan  <= '0;
            for (int k = 0; k < DEG; k++) s1_msg[k] <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_chan <= chan_tc;
                for (int k = 0; k < DEG; k++) s1_msg[k] <= msg_tc[k];
            end
        end
    end

    // Adder chain: intrinsic plus every edge.
    always_comb begin
        total = s1_chan;
        for (int k = 0; k < DEG; k++) total = total + s1_msg[k];
    end

    generate
        for (genvar k = 0; k < DEG; k++) begin : g_out
            // Extrinsic value of edge k.
            assign extr[k] = total - s1_msg[k];

            vnode_compress #(.ACC_W(ACC_W)) u_cmp (
                .value_in (extr[k]),
                .code_out (code_nx[k])
            );

            assign packed_nx[k*MSG_W +: MSG_W] = code_nx[k];

            // R5: a zero extrinsic is always the positive zero code.
            a_r5_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
                (extr[k] == '0) |-> (code_nx[k] == '0));
            // R4: results at or past the clamp take the top positive code.
            a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
                (extr[k] >= ACC_W'(MAG_MAX)) |-> (code_nx[k] == {1'b0, {CODE_W{1'b1}}}));
            // R4: negative results keep their sign bit.
            a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (extr[k] < 0) |-> code_nx[k][CODE_W]);
        end
    endgenerate

    // Stage 2: register compressed outputs and hard decision; hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            msg_out   <= '0;
            hard_bit  <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                msg_out  <= packed_nx;
                hard_bit <= total[ACC_W-1];
            end
        end
    end

    // R7: an accepted slot appears at the output two cycles later.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    // R10: an empty slot yields no output valid two cycles later.
    a_r10_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);
    // R10: outputs hold while no new result is produced.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(msg_out) && $stable(hard_bit)));

endmodule

// File: tb/vnode_pipe_tb_top.sv
module vnode_pipe_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  chan_llr = '0;
    logic [15:0] msg_in = '0;
    logic        out_valid;
    logic [15:0] msg_out;
    logic        hard_bit;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // Expected slots, oldest first.
    logic        q_v[$];
    logic [15:0] q_m[$];
    logic        q_h[$];
    string       q_t[$];
    logic [15:0] held_m = '0;
    logic        held_h = 1'b0;

    vnode_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chan_llr(chan_llr),
        .msg_in(msg_in), .out_valid(out_valid), .msg_out(msg_out), .hard_bit(hard_bit)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
                summary();
                $finish;
            end
        end
    end

    function automatic int mag_of(input int c);
        int reps[8] = '{1, 3, 5, 7, 9, 13, 20, 28};
        return reps[c];
    endfunction

    function automatic logic [3:0] squash(input int v);
        int a;
        int c;
        a = (v < 0) ? -v : v;
        if (a > 31) a = 31;
        c = (a > 24) ? 7 : (a > 16) ? 6 : (a > 10) ? 5 : (a > 7) ? 4 :
            (a > 5) ? 3 : (a > 3) ? 2 : (a > 1) ? 1 : 0;
        return {(v < 0), 3'(c)};
    endfunction

    task automatic compare();
        logic        ev;
        logic [15:0] em;
        logic        eh;
        string       t;
        ev = q_v.pop_front(); em = q_m.pop_front(); eh = q_h.pop_front(); t = q_t.pop_front();
        n_checks++;
        if (out_valid !== ev || msg_out !== em || hard_bit !== eh) begin
            n_fails++;
            $display("FAIL %s: actual v=%b m=%h h=%b expected v=%b m=%h h=%b",
                     t, out_valid, msg_out, hard_bit, ev, em, eh);
        end
    endtask

    // One clock slot: check outputs, then drive and model the next operand set.
    task automatic step(input logic v, input logic [5:0] ch, input logic [15:0] m, input string tag);
        int vals[4];
        int tot;
        @(negedge clk);
        compare();
        in_valid = v; chan_llr = ch; msg_in = m;
        if (v) begin
            tot = ch[5] ? -int'(ch[4:0]) : int'(ch[4:0]);
            for (int k = 0; k < 4; k++) begin
                vals[k] = mag_of(int'(m[4*k +: 3]));
                if (m[4*k+3]) vals[k] = -vals[k];
                tot += vals[k];
            end
            for (int k = 0; k < 4; k++) held_m[4*k +: 4] = squash(tot - vals[k]);
            held_h = (tot < 0);
        end
        q_v.push_back(v); q_m.push_back(held_m); q_h.push_back(held_h); q_t.push_back(tag);
    endtask

    initial begin
        // R9: reset values.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) begin
                n_checks++;
                if (out_valid !== 1'b0 || msg_out !== 16'h0 || hard_bit !== 1'b0) begin
                    n_fails++;
                    $display("FAIL R9: actual v=%b m=%h h=%b expected all zero", out_valid, msg_out, hard_bit);
                end
            end
        end
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            q_v.push_back(1'b0); q_m.push_back(16'h0); q_h.push_back(1'b0); q_t.push_back("R9");
        end

        // R1: each code on edge 0, each sign, others fixed.
        for (int c = 0; c < 16; c++) step(1'b1, 6'd0, {4'h1, 4'h2, 4'h3, 4'(c)}, "R1");
        // R1: each code on edge 3.
        for (int c = 0; c < 16; c++) step(1'b1, 6'd4, {4'(c), 4'hA, 4'h0, 4'h8}, "R1");
        // R2: negative zero versus positive zero intrinsic.
        step(1'b1, 6'b100000, 16'h1234, "R2");
        step(1'b1, 6'b000000, 16'h1234, "R2");
        step(1'b1, 6'b111111, 16'h0000, "R2");
        // R3: mixed signs.
        step(1'b1, 6'd13, 16'h7D2B, "R3");
        step(1'b1, 6'b101001, 16'hC4E1, "R3");
        // R4: saturation both ways.
        step(1'b1, 6'd31, 16'h7777, "R4");
        step(1'b1, 6'b111111, 16'hFFFF, "R4");
        step(1'b1, 6'd20, 16'h6777, "R4");
        // R5: extrinsic of edge 0 is exactly zero (3 + 1 - 3 - 1).
        step(1'b1, 6'd3, {4'h8, 4'h9, 4'h0, 4'h0}, "R5");
        step(1'b1, 6'd0, {4'h8, 4'h8, 4'h0, 4'h0}, "R5");
        // R6: zero, slightly negative, strongly negative sum.
        step(1'b1, 6'd0, {4'h8, 4'h0, 4'h8, 4'h0}, "R6");
        step(1'b1, 6'b100001, {4'h8, 4'h0, 4'h8, 4'h0}, "R6");
        step(1'b1, 6'd2, 16'hF9AB, "R6");
        // R7: isolated slot surrounded by idle slots.
        step(1'b0, 6'd0, 16'h0, "R7");
        step(1'b1, 6'd9, 16'h3B5D, "R7");
        step(1'b0, 6'd0, 16'h0, "R7");
        step(1'b0, 6'd0, 16'h0, "R7");
        // R10: changing inputs while not valid must not disturb the held result.
        for (int i = 0; i < 8; i++) step(1'b0, 6'($urandom), 16'($urandom), "R10");
        // R8: long back-to-back stream with random gaps.
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) != 0, 6'($urandom), 16'($urandom), "R8");
        step(1'b0, 6'd0, 16'h0, "R8");
        step(1'b0, 6'd0, 16'h0, "R8");
        @(negedge clk);
        compare();
        summary();
        $finish;
    end

endmodule